// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the control and status word of a floating-point unit and keeps it current as arithmetic results retire. The word carries a two-bit rounding-mode field, a denormal-flush control bit, a bank-select bit, and three five-bit exception groups: the flags of the latest operation, the enables, and the sticky causes. An arithmetic datapath reports each retired result with a strobe and five exception indications. Compares report their relation together with an unordered indication.

Each retired operation rewrites the flag group with the exception indications. When any indication is set, the flags are also ORed into the cause group, which sits a fixed ten bits above the flags. If a cause bit then meets its set enable bit, a one-cycle trap request goes out with code 0x120. An ordered equality or greater-than compare writes the T bit. An unordered compare leaves T alone and runs the status update in its place. The rounding-mode select and the flush enable are decoded from the stored word and drive the datapath directly.

Top module: `fpu_status_ctl`

## Requirements
- R1: After reset, the status word, the T bit and the trap request are all zero.
- R2: A software write stores only the defined bits of the data (mask 0x0027FFFF): rounding mode [1:0], flags [6:2], enables [11:7], cause [17:12], denormal control [18], bank select [21]. The value appears on the status word on the cycle after the write.
- R3: The round-to-zero select is high exactly when the rounding-mode field [1:0] equals 2'b01. Every other encoding selects round-to-nearest-even (select low).
- R4: The flush-to-zero enable equals the denormal-control bit [18].
- R5: A retired operation replaces the whole flag field with its five exception indications. Within each five-bit group the bit order from low to high is inexact, underflow, overflow, divide-by-zero, invalid.
- R6: When any exception indication is set, the new flags are ORed into cause bits [16:12], and earlier cause bits are kept. Cause bit [17] is written only by software.
- R7: A retired operation with no exception indication clears the flags, leaves the cause field unchanged and raises no trap.
- R8: A retired operation with at least one exception indication raises the trap request for exactly one cycle, on the cycle after the strobe, when (cause[16:12] OR new flags) AND enables [11:7] is nonzero. This includes cause bits left over from earlier operations. The trap code output then reads 0x120.
- R9: An ordered compare writes T with the equality result for an equal compare (kind 0) and with the greater-than result for a greater-than compare (kind 1).
- R10: An unordered compare leaves T unchanged and applies the status update of R5 to R8 using the exception indications presented with it.
- R11: When a status update and a software write fall in the same cycle, the update takes effect and the write is dropped.
- R12: In a cycle with no write, no retired operation and no unordered compare, the status word keeps its value.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write data |
| opValid | input | 1 | Arithmetic result retired |
| excBits | input | 5 | Exception indications {invalid, divzero, overflow, underflow, inexact} |
| cmpValid | input | 1 | Compare result valid |
| cmpKind | input | 1 | 0 = equality compare, 1 = greater-than compare |
| cmpEq | input | 1 | Operands compare equal |
| cmpGt | input | 1 | First operand is greater |
| cmpUnord | input | 1 | Operands are unordered |
| csrValue | output | 32 | Stored status/control word |
| roundToZero | output | 1 | 1 = truncate, 0 = round to nearest even |
| flushEn | output | 1 | Flush denormals to zero |
| tBit | output | 1 | Compare result bit |
| trapReq | output | 1 | One-cycle trap request |
| trapCode | output | 12 | Trap exception code (0x120) |

## Verification
The bench targets the trap that comes from a stale cause bit. A design that tested only the fresh flags against the enables would stay silent there. It also checks that an operation with no exception leaves the cause field untouched and raises no trap, which catches a design that clears cause or traps from old state. Unordered compares with a distinct T value show whether T gets overwritten. A write that collides with an update shows which one wins. Each rounding encoding is written in turn, so a decode that treats any nonzero mode as truncation is exposed.

// File: rtl/fpu_status_pkg.sv
package fpu_status_pkg;

  localparam int CSR_W     = 32;
  localparam int EXC_W     = 5;
  localparam int RM_LO     = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LO   = 2;
  localparam int EN_LO     = 7;
  localparam int CAUSE_LO  = 12;
  localparam int CAUSE_W   = 6;
  localparam int DN_BIT    = 18;
  localparam int BANK_BIT  = 21;
  localparam int CAUSE_SHIFT = CAUSE_LO - FLAG_LO;
  localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;
  localparam logic [11:0] TRAP_FP_EXC = 12'h120;

  // Bit index of each exception inside a five-bit group
  localparam int EXC_INEXACT  = 0;
  localparam int EXC_UNDER    = 1;
  localparam int EXC_OVER     = 2;
  localparam int EXC_DIVZERO  = 3;
  localparam int EXC_INVALID  = 4;

  typedef enum logic {CMP_EQ = 1'b0, CMP_GT = 1'b1} cmpKind_t;

  typedef struct packed {
    logic doWrite;
    logic doUpdate;
    logic doSetT;
    logic tVal;
  } ctlStrobes_t;

  function automatic logic [CSR_W-1:0] fieldMask(input int lo, input int w);
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lo+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CSR_W-1:0] writeMask();
    return fieldMask(RM_LO, RM_W) | fieldMask(FLAG_LO, EXC_W) |
           fieldMask(EN_LO, EXC_W) | fieldMask(CAUSE_LO, CAUSE_W) |
           fieldMask(DN_BIT, 1) | fieldMask(BANK_BIT, 1);
  endfunction

endpackage

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpu_status_pkg::*;
#(
  parameter int EXC_BITS = EXC_W
) (
  input  logic                wrEn,
  input  logic                opValid,
  input  logic                cmpValid,
  input  logic                cmpKind,
  input  logic                cmpEq,
  input  logic                cmpGt,
  input  logic                cmpUnord,
  output ctlStrobes_t         strobes
);

  logic orderedCmp;
  logic unorderedCmp;
  cmpKind_t kind;

  always_comb begin
    kind         = cmpKind_t'(cmpKind);
    orderedCmp   = cmpValid && !cmpUnord;
    unorderedCmp = cmpValid && cmpUnord;

    strobes          = '0;
    // Status update has priority over a colliding software write
    strobes.doUpdate = opValid || unorderedCmp;
    strobes.doWrite  = wrEn && !strobes.doUpdate;
    strobes.doSetT   = orderedCmp;
    unique case (kind)
      CMP_EQ:  strobes.tVal = cmpEq;
      CMP_GT:  strobes.tVal = cmpGt;
      default: strobes.tVal = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpu_status_dp.sv
module fpu_status_dp
  import fpu_status_pkg::*;
#(
  parameter int WIDTH    = CSR_W,
  parameter int EXC_BITS = EXC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [WIDTH-1:0]    wrData,
  input  logic [EXC_BITS-1:0] excBits,
  output logic [WIDTH-1:0]    csrValue,
  output logic                roundToZero,
  output logic                flushEn,
  output logic                tBit,
  output logic                trapReq
);

  localparam logic [WIDTH-1:0] WMASK     = writeMask();
  localparam logic [WIDTH-1:0] FLAG_MASK = fieldMask(FLAG_LO, EXC_BITS);

  logic [WIDTH-1:0]    csrQ, csrD, updVal;
  logic [EXC_BITS-1:0] causeNew, enables, hit;
  logic                trapD, anyExc;

  // Status update: rewrite flags, accumulate cause by a fixed shift
  always_comb begin
    anyExc = |excBits;
    updVal = csrQ & ~FLAG_MASK;
    updVal[FLAG_LO +: EXC_BITS] = excBits;
    if (anyExc) updVal = updVal | ((updVal & FLAG_MASK) << CAUSE_SHIFT);
    causeNew = updVal[CAUSE_LO +: EXC_BITS];
    enables  = updVal[EN_LO +: EXC_BITS];
  end

  // Per-exception trap match
  for (genvar g = 0; g < EXC_BITS; g++) begin : g_match
    assign hit[g] = causeNew[g] & enables[g];
  end

  always_comb begin
    csrD  = csrQ;
    trapD = 1'b0;
    if (strobes.doUpdate) begin
      csrD  = updVal;
      trapD = anyExc && (|hit);
    end else if (strobes.doWrite) begin
      csrD = wrData & WMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrQ    <= '0;
      tBit    <= 1'b0;
      trapReq <= 1'b0;
    end else begin
      csrQ    <= csrD;
      trapReq <= trapD;
      if (strobes.doSetT) tBit <= strobes.tVal;
    end
  end

  assign csrValue    = csrQ;
  assign roundToZero = (csrQ[RM_LO +: RM_W] == RM_TRUNC);
  assign flushEn     = csrQ[DN_BIT];

endmodule

// File: rtl/fpu_status_ctl.sv
module fpu_status_ctl
  import fpu_status_pkg::*;
#(
  parameter int          WIDTH     = CSR_W,
  parameter int          EXC_BITS  = EXC_W,
  parameter logic [11:0] TRAP_CODE = TRAP_FP_EXC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WIDTH-1:0]    wrData,
  input  logic                opValid,
  input  logic [EXC_BITS-1:0] excBits,
  input  logic                cmpValid,
  input  logic                cmpKind,
  input  logic                cmpEq,
  input  logic                cmpGt,
  input  logic                cmpUnord,
  output logic [WIDTH-1:0]    csrValue,
  output logic                roundToZero,
  output logic                flushEn,
  output logic                tBit,
  output logic                trapReq,
  output logic [11:0]         trapCode
);

  ctlStrobes_t strobes;

  fpu_status_ctrl #(.EXC_BITS(EXC_BITS)) u_ctrl (
    .wrEn     (wrEn),
    .opValid  (opValid),
    .cmpValid (cmpValid),
    .cmpKind  (cmpKind),
    .cmpEq    (cmpEq),
    .cmpGt    (cmpGt),
    .cmpUnord (cmpUnord),
    .strobes  (strobes)
  );

  fpu_status_dp #(.WIDTH(WIDTH), .EXC_BITS(EXC_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .excBits     (excBits),
    .csrValue    (csrValue),
    .roundToZero (roundToZero),
    .flushEn     (flushEn),
    .tBit        (tBit),
    .trapReq     (trapReq)
  );

  assign trapCode = TRAP_CODE;

endmodule

// File: rtl/fpu_status_chk.sv
module fpu_status_chk
  import fpu_status_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic        opValid,
  input logic [4:0]  excBits,
  input logic        cmpValid,
  input logic        cmpUnord,
  input logic [31:0] csrValue,
  input logic        tBit,
  input logic        trapReq
);

  logic upd;
  assign upd = opValid || (cmpValid && cmpUnord);

  // R2: masked software write lands one cycle later
  a_r2_write_mask: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !upd) |=> (csrValue == ($past(wrData) & 32'h0027FFFF)));

  // R5: flags mirror the exception indications after an update
  a_r5_flags_rewrite: assert property (@(posedge clk) disable iff (!rstN)
    upd |=> (csrValue[6:2] == $past(excBits)));

  // R7: a clean update never traps and keeps cause
  a_r7_clean_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (upd && excBits == 5'd0) |=> (!trapReq && csrValue[17:12] == $past(csrValue[17:12])));

  // R8: trap only follows an update carrying an exception
  a_r8_trap_source: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($past(upd) && $past(excBits) != 5'd0));

  // R10: unordered compare never moves T
  a_r10_t_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpUnord) |=> $stable(tBit));

  // R12: idle cycle keeps the word
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !upd) |=> $stable(csrValue));

endmodule

bind fpu_status_ctl fpu_status_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .opValid  (opValid),
  .excBits  (excBits),
  .cmpValid (cmpValid),
  .cmpUnord (cmpUnord),
  .csrValue (csrValue),
  .tBit     (tBit),
  .trapReq  (trapReq)
);

// File: tb/sim_fpu_status_ctl.sv
module sim_fpu_status_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        opValid = 1'b0;
  logic [4:0]  excBits = '0;
  logic        cmpValid = 1'b0, cmpKind = 1'b0, cmpEq = 1'b0, cmpGt = 1'b0, cmpUnord = 1'b0;
  logic [31:0] csrValue;
  logic        roundToZero, flushEn, tBit, trapReq;
  logic [11:0] trapCode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpu_status_ctl u0 (.*);

  typedef struct {
    logic [31:0] csr;
    logic        t;
    logic        trap;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] mCsr = '0;
  logic        mT = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input bit we, input logic [31:0] wd, input bit ov, input logic [4:0] ex,
                      input bit cv, input bit ck, input bit ceq, input bit cgt, input bit cun,
                      input string tag);
    expItem_t it;
    logic upd;
    logic trap;
    @(negedge clk);
    wrEn = we; wrData = wd; opValid = ov; excBits = ex;
    cmpValid = cv; cmpKind = ck; cmpEq = ceq; cmpGt = cgt; cmpUnord = cun;
    upd = ov | (cv & cun);
    trap = 1'b0;
    if (upd) begin
      mCsr[6:2] = ex;
      if (ex != 5'd0) begin
        mCsr[16:12] = mCsr[16:12] | ex;
        trap = |(mCsr[16:12] & mCsr[11:7]);
      end
    end else if (we) begin
      mCsr = wd & 32'h0027FFFF;
    end
    if (cv && !cun) mT = ck ? cgt : ceq;
    it.csr = mCsr; it.t = mT; it.trap = trap; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
    #0;
    wrEn = 1'b0; opValid = 1'b0; cmpValid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(1, d, 0, 5'd0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic op(input logic [4:0] e, input string tag);
    step(0, '0, 1, e, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, '0, 0, 5'd0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pop and compare just after each edge
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, "csr", csrValue, e.csr);
      check(e.tag, "tBit", {31'd0, tBit}, {31'd0, e.t});
      check(e.tag, "trapReq", {31'd0, trapReq}, {31'd0, e.trap});
      check("R3", "roundToZero", {31'd0, roundToZero}, {31'd0, (e.csr[1:0] == 2'b01)});
      check("R4", "flushEn", {31'd0, flushEn}, {31'd0, e.csr[18]});
      if (trapReq) check("R8", "trapCode", {20'd0, trapCode}, 32'h120);
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset csr", csrValue, 32'h0);
    check("R1", "reset t", {31'd0, tBit}, 32'h0);
    check("R1", "reset trap", {31'd0, trapReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    wr(32'hFFFF_FFFF, "R2");          // mask
    wr(32'h0000_0000, "R2");
    wr(32'h0000_0001, "R3");          // truncate
    wr(32'h0000_0002, "R3");
    wr(32'h0000_0003, "R3");
    wr(32'h0004_0000, "R4");          // flush enable
    wr(32'h0000_0000, "R4");

    op(5'b10101, "R5");               // flags and cause, no enables
    op(5'b00010, "R6");               // flags replaced, cause accumulates
    op(5'b00000, "R7");               // clean op keeps cause
    idle("R12");

    // enable divide-by-zero only (enable bit 7+3 = 10)
    wr(32'h0000_0400, "R2");
    op(5'b00001, "R8");               // inexact only: no match
    op(5'b01000, "R8");               // divzero: trap
    idle("R8");                       // trap lasts one cycle
    op(5'b00010, "R8");               // stale divzero cause traps again
    op(5'b00000, "R7");               // clean: no trap despite stale cause

    // compares
    step(0, '0, 0, 5'd0, 1, 0, 1, 0, 0, "R9");   // eq true
    step(0, '0, 0, 5'd0, 1, 1, 1, 0, 0, "R9");   // gt false
    step(0, '0, 0, 5'd0, 1, 1, 0, 1, 0, "R9");   // gt true
    step(0, '0, 0, 5'd0, 1, 0, 0, 1, 1, "R10");  // unordered, T held at 1
    step(0, '0, 0, 5'd0, 1, 0, 0, 0, 0, "R9");   // eq false -> 0
    step(0, '0, 0, 5'd0, 1, 0, 1, 1, 1, "R10");  // unordered w/o exc: T held 0
    step(0, '0, 0, 5'b10000, 1, 1, 1, 1, 1, "R10"); // unordered invalid
    // collision: update wins
    step(1, 32'h0027_FFFF, 1, 5'b00100, 0, 0, 0, 0, 0, "R11");
    idle("R12");
    idle("R12");

    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule